// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block sequences four independent DMA channels through enabling, arming, triggering, running and ending. Each channel has an 8-bit control byte holding an enable flag (bit 7) and an active flag (bit 0), a 10-bit handshake count and a 4-bit hardware-trigger source select. Software writes these through a single write port. The port writes a whole byte or, in bit mode, one addressed control bit. The control bytes are read back through a combinational read port.

A channel that is enabled and active is armed. A software trigger, or the hardware source that its select field picks out of a 16-line vector, starts one run. A run is a train of transfer requests, and each request waits for an acknowledge before the next one counts. When the programmed number of acknowledges has been taken, the channel clears its active flag and pulses its completion interrupt for one cycle. Software can end a run early by writing the active flag to 0. The channel then stops without an interrupt. The enable flag is locked while the active flag is set.

Each channel runs a three-state machine:
- IDLE goes to ARMED when enable and active are both 1 and no abort write is present.
- ARMED goes to BUSY on a trigger, and back to IDLE when an abort write clears the active flag.
- BUSY goes to IDLE on the final acknowledge (this is completion) or on an abort write.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset every control byte reads 0x00. Bits 6 to 1 of a control byte always read 0.
- R2: A channel's clock-enable output equals its enable flag (bit 7). With the flag at 0 the channel never raises a request.
- R3: A channel responds to triggers only while enable and active are both 1. With active set and enable clear, triggers are ignored.
- R4: A software trigger pulse on an armed channel raises its request output two clock edges after the edge that armed it at the earliest, and one edge after the trigger is sampled.
- R5: The hardware trigger comes from hw_src[sel], where sel is the channel's 4-bit source select (register code 2). Other hw_src lines have no effect.
- R6: One trigger runs N acknowledge handshakes, where N is the channel's count register (register code 1). The request stays high until the N-th acknowledge. A count of 0 means 1024.
- R7: The edge that takes the N-th acknowledge clears the active flag and drops the request. The completion interrupt is high for exactly the following cycle.
- R8: Writing 0 to the active flag while armed or busy returns the channel to idle, drops the request and raises no completion interrupt.
- R9: A write to the enable flag takes effect only when the active flag is 0. Otherwise the enable flag keeps its value, even when the same write sets or clears the active flag.
- R10: Control writes use register code 0. In bit mode (wr_bitop=1), only control bit wr_bitpos is written, with the value wr_data[0]. In byte mode, bits 7 and 0 come from wr_data[7:0].
- R11: Software or hardware triggers that arrive during a run neither restart it nor extend it.
- R12: The four channels run independently. Activity on one channel does not change the request, interrupt or register state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 2 | Channel being written |
| wr_reg | input | 2 | Register code: 0 control, 1 count, 2 source select |
| wr_bitop | input | 1 | Bit mode for control writes |
| wr_bitpos | input | 3 | Control bit addressed in bit mode |
| wr_data | input | 10 | Write data |
| rd_ch | input | 2 | Channel whose control byte is read |
| rd_ctrl | output | 8 | Control byte of channel rd_ch |
| sw_trig | input | 4 | Software trigger, one per channel |
| hw_src | input | 16 | Hardware trigger sources |
| xfer_ack | input | 4 | Transfer acknowledge, one per channel |
| xfer_req | output | 4 | Transfer request, one per channel |
| done_irq | output | 4 | Completion pulse, one per channel |
| clk_en | output | 4 | Channel clock enable |

## Verification
The bench tries to clear the enable flag while active. A design without the lock would read back 0x01 instead of 0x81, and would also let 0x81 enable a channel that has active set and enable clear. It aborts a run partway through. A faulty abort would still pulse the interrupt, or leave the request high. It fires triggers during a run and with a count of 0. A design that reloads on a retrigger, or treats 0 as "no transfers", would miss the interrupt after exactly N or 1024 acknowledges. It also drives a hardware line that is not selected, and bit-mode writes to an unused bit. Decoding that is wrong in either case shows up as a false request or a changed readback.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_BUSY  = 2'd2
    } ch_state_e;

    localparam int CTRL_W       = 8;
    localparam int EN_BIT       = 7;
    localparam int ACT_BIT      = 0;
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_CNT  = 2'd1;
    localparam logic [1:0] REG_SEL  = 2'd2;
endpackage

// File: rtl/dmaseq_wrdec.sv
module dmaseq_wrdec
    import dmaseq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 10,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [1:0]        wr_reg,
    input  logic              wr_bitop,
    input  logic [2:0]        wr_bitpos,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NCH-1:0]    ctl_we,
    output logic [NCH-1:0]    cnt_we,
    output logic [NCH-1:0]    sel_we,
    output logic [CTRL_W-1:0] ctl_mask,
    output logic [CTRL_W-1:0] ctl_byte
);
    always_comb begin
        ctl_mask = wr_bitop ? (CTRL_W'(1) << wr_bitpos) : {CTRL_W{1'b1}};
        ctl_byte = wr_bitop ? {CTRL_W{wr_data[0]}} : wr_data[CTRL_W-1:0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        always_comb begin
            ctl_we[c] = wr_en && (wr_ch == CH_W'(c)) && (wr_reg == REG_CTRL);
            cnt_we[c] = wr_en && (wr_ch == CH_W'(c)) && (wr_reg == REG_CNT);
            sel_we[c] = wr_en && (wr_ch == CH_W'(c)) && (wr_reg == REG_SEL);
        end
    end
endmodule

// File: rtl/dmaseq_chan.sv
module dmaseq_chan
    import dmaseq_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int SRC_W = 4,
    localparam int NSRC = 2 ** SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTRL_W-1:0] ctl_mask,
    input  logic [CTRL_W-1:0] ctl_byte,
    input  logic              cnt_we,
    input  logic              sel_we,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              sw_trig,
    input  logic [NSRC-1:0]   hw_src,
    input  logic              ack,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic              req,
    output logic              irq,
    output logic              clk_en
);
    ch_state_e        state_q, state_d;
    logic             en_q, en_d, act_q, act_d, irq_q, irq_d;
    logic [CNT_W-1:0] rem_q, rem_d, cnt_q, cnt_d;
    logic [SRC_W-1:0] sel_q, sel_d;
    logic             wr_act, wr_en_bit, abort, trig;

    always_comb begin
        wr_act    = ctl_we && ctl_mask[ACT_BIT];
        wr_en_bit = ctl_we && ctl_mask[EN_BIT];
        abort     = wr_act && !ctl_byte[ACT_BIT];
        trig      = sw_trig || hw_src[sel_q];
        cnt_d     = cnt_we ? wdata : cnt_q;
        sel_d     = sel_we ? wdata[SRC_W-1:0] : sel_q;
        en_d      = (wr_en_bit && !act_q) ? ctl_byte[EN_BIT] : en_q;
        act_d     = act_q;
        rem_d     = rem_q;
        irq_d     = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (wr_act) act_d = ctl_byte[ACT_BIT];
                if (en_q && act_q && !abort) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (abort) begin
                    act_d   = 1'b0;
                    state_d = CH_IDLE;
                end else if (trig) begin
                    rem_d   = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
                    state_d = CH_BUSY;
                end
            end
            CH_BUSY: begin
                if (abort) begin
                    act_d   = 1'b0;
                    state_d = CH_IDLE;
                end else if (ack) begin
                    if (rem_q == '0) begin
                        act_d   = 1'b0;
                        irq_d   = 1'b1;
                        state_d = CH_IDLE;
                    end else begin
                        rem_d = rem_q - {{(CNT_W-1){1'b0}}, 1'b1};
                    end
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            en_q    <= 1'b0;
            act_q   <= 1'b0;
            irq_q   <= 1'b0;
            rem_q   <= '0;
            cnt_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
            act_q   <= act_d;
            irq_q   <= irq_d;
            rem_q   <= rem_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        req     = (state_q == CH_BUSY);
        irq     = irq_q;
        clk_en  = en_q;
        ctrl_rd = '0;
        ctrl_rd[EN_BIT]  = en_q;
        ctrl_rd[ACT_BIT] = act_q;
    end

    a_r9_en_locked: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |=> $stable(en_q));
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    a_r7_irq_clears_act: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (!act_q && state_q == CH_IDLE));
    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_IDLE && abort) |=> (!irq_q && !act_q && state_q == CH_IDLE));
    a_r3_busy_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_IDLE) |-> (en_q && act_q));
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_BUSY && !ack && !abort) |=> (state_q == CH_BUSY && $stable(rem_q)));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dmaseq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 10,
    parameter int SRC_W = 4,
    localparam int CH_W = $clog2(NCH),
    localparam int NSRC = 2 ** SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [1:0]        wr_reg,
    input  logic              wr_bitop,
    input  logic [2:0]        wr_bitpos,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [CTRL_W-1:0] rd_ctrl,
    input  logic [NCH-1:0]    sw_trig,
    input  logic [NSRC-1:0]   hw_src,
    input  logic [NCH-1:0]    xfer_ack,
    output logic [NCH-1:0]    xfer_req,
    output logic [NCH-1:0]    done_irq,
    output logic [NCH-1:0]    clk_en
);
    logic [NCH-1:0]    ctl_we, cnt_we, sel_we;
    logic [CTRL_W-1:0] ctl_mask, ctl_byte;
    logic [CTRL_W-1:0] ctrl_arr [NCH];

    dmaseq_wrdec #(.NCH(NCH), .CNT_W(CNT_W)) u_dec (
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_reg(wr_reg), .wr_bitop(wr_bitop),
        .wr_bitpos(wr_bitpos), .wr_data(wr_data), .ctl_we(ctl_we),
        .cnt_we(cnt_we), .sel_we(sel_we), .ctl_mask(ctl_mask), .ctl_byte(ctl_byte)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dmaseq_chan #(.CNT_W(CNT_W), .SRC_W(SRC_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we[c]), .ctl_mask(ctl_mask),
            .ctl_byte(ctl_byte), .cnt_we(cnt_we[c]), .sel_we(sel_we[c]),
            .wdata(wr_data), .sw_trig(sw_trig[c]), .hw_src(hw_src),
            .ack(xfer_ack[c]), .ctrl_rd(ctrl_arr[c]), .req(xfer_req[c]),
            .irq(done_irq[c]), .clk_en(clk_en[c])
        );
    end

    assign rd_ctrl = ctrl_arr[rd_ch];

    a_r1_pad_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl[6:1] == 6'd0);
    a_r2_req_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req & ~clk_en) == '0);
endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;
    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, wr_bitop = 0;
    logic [1:0] wr_ch = 0, wr_reg = 0, rd_ch = 0;
    logic [2:0] wr_bitpos = 0;
    logic [9:0] wr_data = 0;
    logic [7:0] rd_ctrl;
    logic [3:0] sw_trig = 0, xfer_ack = 0, xfer_req, done_irq, clk_en;
    logic [15:0] hw_src = 0;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dma_chan_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_reg(wr_reg),
        .wr_bitop(wr_bitop), .wr_bitpos(wr_bitpos), .wr_data(wr_data),
        .rd_ch(rd_ch), .rd_ctrl(rd_ctrl), .sw_trig(sw_trig), .hw_src(hw_src),
        .xfer_ack(xfer_ack), .xfer_req(xfer_req), .done_irq(done_irq), .clk_en(clk_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] rs, input logic [1:0] ch, input logic [9:0] d,
                      input bit bop, input logic [2:0] pos);
        wr_reg = rs; wr_ch = ch; wr_data = d; wr_bitop = bop; wr_bitpos = pos; wr_en = 1;
        @(negedge clk);
        wr_en = 0; wr_bitop = 0;
    endtask

    function automatic logic [7:0] rd(input logic [1:0] ch);
        rd_ch = ch;
        return u0.rd_ctrl;
    endfunction

    task automatic chk_ctrl(input logic [1:0] ch, input logic [7:0] exp, input string tag);
        rd_ch = ch; #1;
        chk(rd_ctrl == exp, tag, rd_ctrl, exp);
    endtask

    task automatic arm(input logic [1:0] ch);
        wr(2'd0, ch, 10'h81, 0, 0);
        @(negedge clk);
    endtask

    task automatic pulse_sw(input logic [1:0] ch);
        sw_trig[ch] = 1; @(negedge clk); sw_trig[ch] = 0;
    endtask

    // holds ack for n cycles, checking the request before each one
    task automatic run_acks(input logic [1:0] ch, input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (!xfer_req[ch] || done_irq[ch]) bad++;
            xfer_ack[ch] = 1;
            @(negedge clk);
        end
        xfer_ack[ch] = 0;
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset;
        for (int c = 0; c < 4; c++) chk_ctrl(2'(c), 8'h00, "R1 reset ctrl");
        chk(clk_en == 4'h0 && xfer_req == 0, "R2 reset outputs", {clk_en, xfer_req}, 0);
    endtask

    task automatic t_disabled;
        pulse_sw(0); @(negedge clk);
        chk(xfer_req[0] == 0, "R2 no req when disabled", xfer_req[0], 0);
        wr(2'd0, 0, 10'h01, 0, 0);
        chk_ctrl(0, 8'h01, "R3 act without en");
        wr(2'd0, 0, 10'h81, 0, 0);
        chk_ctrl(0, 8'h01, "R9 en blocked by act");
        pulse_sw(0); @(negedge clk);
        chk(xfer_req[0] == 0 && clk_en[0] == 0, "R3 no trigger response", {clk_en[0], xfer_req[0]}, 0);
        wr(2'd0, 0, 10'h00, 0, 0);
        chk_ctrl(0, 8'h00, "R1 cleared");
    endtask

    task automatic t_bitmode;
        wr(2'd0, 1, 10'h001, 1, 3'd7);
        chk_ctrl(1, 8'h80, "R10 bit set en");
        chk(clk_en[1] == 1, "R2 clk_en follows en", clk_en[1], 1);
        wr(2'd0, 1, 10'h3FF, 1, 3'd3);
        chk_ctrl(1, 8'h80, "R10 unused bit write, R1 pad zero");
        wr(2'd0, 1, 10'h001, 1, 3'd0);
        chk_ctrl(1, 8'h81, "R10 bit set act");
        wr(2'd0, 1, 10'h000, 1, 3'd7);
        chk_ctrl(1, 8'h81, "R9 bit clear en while active");
        wr(2'd0, 1, 10'h000, 1, 3'd0);
        chk_ctrl(1, 8'h80, "R10 bit clear act keeps en");
        wr(2'd0, 1, 10'h000, 0, 0);
        chk_ctrl(1, 8'h00, "R10 byte clear");
    endtask

    task automatic t_sw_run;
        wr(2'd1, 0, 10'd4, 0, 0);
        arm(0);
        chk(xfer_req[0] == 0, "R3 armed no req yet", xfer_req[0], 0);
        pulse_sw(0);
        chk(xfer_req[0] == 1, "R4 sw trigger req", xfer_req[0], 1);
        wr(2'd0, 0, 10'h01, 0, 0);
        chk_ctrl(0, 8'h81, "R9 en kept while active");
        sw_trig[0] = 1; hw_src = 16'hFFFF;
        run_acks(0, 4, "R6 req held for 4 acks, R11 retrigger ignored");
        sw_trig[0] = 0; hw_src = 0;
        chk(done_irq[0] == 1 && xfer_req[0] == 0, "R7 irq on completion", {done_irq[0], xfer_req[0]}, 2);
        chk_ctrl(0, 8'h80, "R7 act cleared");
        @(negedge clk);
        chk(done_irq[0] == 0, "R7 irq single cycle", done_irq[0], 0);
        chk(xfer_req[0] == 0, "R11 no rerun after done", xfer_req[0], 0);
    endtask

    task automatic t_hw_sel;
        wr(2'd2, 1, 10'd5, 0, 0);
        wr(2'd1, 1, 10'd3, 0, 0);
        arm(1);
        hw_src[3] = 1; @(negedge clk); hw_src[3] = 0; @(negedge clk);
        chk(xfer_req[1] == 0, "R5 unselected source ignored", xfer_req[1], 0);
        hw_src[5] = 1; @(negedge clk); hw_src[5] = 0;
        chk(xfer_req[1] == 1, "R5 selected source starts", xfer_req[1], 1);
        run_acks(1, 3, "R6 three acks");
        chk(done_irq[1] == 1, "R7 irq ch1", done_irq[1], 1);
    endtask

    task automatic t_abort;
        wr(2'd1, 2, 10'd5, 0, 0);
        arm(2);
        pulse_sw(2);
        run_acks(2, 2, "R6 partial run");
        wr(2'd0, 2, 10'h00, 0, 0);
        chk(xfer_req[2] == 0 && done_irq[2] == 0, "R8 abort stops quietly", {xfer_req[2], done_irq[2]}, 0);
        chk_ctrl(2, 8'h80, "R8 act cleared R9 en kept");
        xfer_ack[2] = 1;
        repeat (4) begin
            @(negedge clk);
            chk(done_irq[2] == 0 && xfer_req[2] == 0, "R8 no late irq", {xfer_req[2], done_irq[2]}, 0);
        end
        xfer_ack[2] = 0;
        arm(2);
        wr(2'd0, 2, 10'h00, 0, 0);
        pulse_sw(2);
        chk(xfer_req[2] == 0, "R8 abort while armed", xfer_req[2], 0);
    endtask

    task automatic t_indep;
        wr(2'd1, 0, 10'd2, 0, 0);
        wr(2'd1, 3, 10'd1, 0, 0);
        arm(0); arm(3);
        pulse_sw(0);
        chk(xfer_req == 4'b0001, "R12 only ch0 runs", xfer_req, 1);
        pulse_sw(3);
        run_acks(3, 1, "R12 ch3 run");
        chk(done_irq == 4'b1000 && xfer_req == 4'b0001, "R12 ch3 done, ch0 busy", {done_irq, xfer_req}, 8'h81);
        chk_ctrl(0, 8'h81, "R12 ch0 still active");
        run_acks(0, 2, "R12 ch0 finishes");
        chk(done_irq == 4'b0001, "R12 ch0 irq", done_irq, 1);
    endtask

    task automatic t_zero_count;
        wr(2'd1, 3, 10'd0, 0, 0);
        arm(3);
        pulse_sw(3);
        run_acks(3, 1024, "R6 count 0 runs 1024");
        chk(done_irq[3] == 1 && xfer_req[3] == 0, "R6 done after 1024", {done_irq[3], xfer_req[3]}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_bitmode();
        t_sw_run();
        t_hw_sel();
        t_abort();
        t_indep();
        t_zero_count();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule